// File: doc/BRIEF.md
# Complement-Paired Table Lookup Engine

This block evaluates two 4-bit cipher sub-functions, key addition followed by substitution, across eight byte lanes at once. Both sub-functions are held as 32-entry tables of 5-bit words. The index is one bit wider than the function input, and so is each word. The lower half of a table, at index `0|X`, holds `0|F(X)`. The upper half, at index `1|~X`, holds `1|~F(X)`. A lane that carries a value with its tag bit clear and a lane that carries the complement with its tag bit set therefore read entries that are bitwise complements of each other. Such a pair has a constant Hamming weight of five. It leaves one stage in the form the next stage expects, so the pair passes through both stages with no re-encoding.

In secure mode, software places four value/complement pairs on the lanes (even lane = `0|X`, odd lane = `1|~X`) and obtains four protected results. In fast mode, the block forces the tag bit of every index to zero before each lookup. All eight lanes then read the lower halves as independent instances. The same datapath and the same tables serve both modes. Tables are written through a load port, one entry per cycle, and only while no lookup is in progress.

Top module: `cplut_engine`

## Requirements
- R1: After reset, `done` is 0 and every bit of `result` is 0.
- R2: In secure mode, a lane pair carrying (`0|X`, `1|~X`) produces (`0|Y`, `1|~Y`), where Y is the substitution applied to X XOR key. The tables hold `0|F(x)` at index `x` and `1|~F(x)` at index `16 + (~x & 15)`.
- R3: In secure mode, with correctly loaded tables and pair-formatted inputs, the 10 result bits of each lane pair (lanes 2p and 2p+1) contain exactly five ones.
- R4: With the substitution {12,5,6,11,9,0,10,13,3,14,15,8,4,7,1,2} loaded and an identity key table, the pair for X=0 gives 12 and 19, and the pair for X=15 gives 2 and 29.
- R5: The key stage returns X XOR K for whatever key K its table was filled with, so reloading the key table alone changes results accordingly.
- R6: In fast mode (`secure_mode`=0), bit 4 of every lane index is treated as 0 at both stages, and each of the eight lanes is computed independently.
- R7: A table write (`load_en`=1, `load_sel` 0 = key table, 1 = substitution table, 5-bit `load_addr`) takes effect only when the unit is idle. A write presented while a lookup is in progress is discarded.
- R8: If `start` is accepted at clock edge k, the key result is registered at edge k, the substitution result is registered at edge k+1, and `done` is high for exactly one cycle, starting at edge k+2.
- R9: A `start` raised while a lookup is in progress is ignored. It produces no extra `done` and does not alter the result.
- R10: The mode is sampled when `start` is accepted. Changing `secure_mode` during the operation has no effect on it.
- R11: Each result byte carries the 5-bit word in bits 4:0 and zeros in bits 7:5. Input bits 7:5 are ignored. `result` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a lookup on `lane_in` (accepted when idle) |
| secure_mode | input | 1 | 1 = complement-paired lanes, 0 = eight independent lanes |
| lane_in | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| load_en | input | 1 | Table write strobe |
| load_sel | input | 1 | 0 = key table, 1 = substitution table |
| load_addr | input | 5 | Table index to write |
| load_data | input | 5 | Word to write |
| result | output | 64 | Eight result bytes, lane 0 in bits 7:0 |
| done | output | 1 | One-cycle pulse when `result` is valid |

## Verification
Each accepted start is due to produce `done` and a final `result` three rising edges later, counting the edge that samples `start`. The driver records the edge count at which it raises `start` and pushes the expected lane vector with that count. The monitor samples on falling edges, so it sees the pulse midway through the cycle after the third edge. There it checks both the value and the exact edge distance, and it flags any `done` that arrives with nothing queued or lasts two cycles. Ignored loads and ignored starts are checked through later results and the count of `done` pulses.

// File: rtl/cplut_pkg.sv
package cplut_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_KEY  = 2'd1,
    PH_SUB  = 2'd2,
    PH_FIN  = 2'd3
  } phase_t;

  localparam logic SEL_KEY = 1'b0;
  localparam logic SEL_SUB = 1'b1;
endpackage

// File: rtl/cplut_table.sv
module cplut_table #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_addr,
  input  logic [IDX_W-1:0]                 wr_data,
  input  logic [LANES-1:0][IDX_W-1:0]      rd_addr,
  output logic [LANES-1:0][IDX_W-1:0]      rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][IDX_W-1:0] mem_q;

  // storage array: no reset, written only through the clock enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rd_data[g] = mem_q[rd_addr[g]];
  end

  // R7: contents only move when a gated write arrives
  assert_table_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/cplut_stage.sv
module cplut_stage #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         secure,
  input  logic [LANES-1:0][IDX_W-1:0]  src,
  output logic [LANES-1:0][IDX_W-1:0]  tbl_addr,
  input  logic [LANES-1:0][IDX_W-1:0]  tbl_data,
  output logic [LANES-1:0][IDX_W-1:0]  q
);
  localparam int unsigned TAG = IDX_W - 1;

  logic [LANES-1:0][IDX_W-1:0] q_q, q_d;

  // fast mode drops the tag so every lane reads the lower half
  for (genvar g = 0; g < LANES; g++) begin : g_addr
    assign tbl_addr[g] = secure ? src[g] : {1'b0, src[g][TAG-1:0]};
  end

  always_comb begin
    q_d = q_q;
    if (en) begin
      q_d = tbl_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

  // R11: a stage result is held while its enable is low
  assert_stage_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_q));
endmodule

// File: rtl/cplut_ctrl.sv
module cplut_ctrl
  import cplut_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic secure_in,
  output logic accept,
  output logic sub_en,
  output logic idle,
  output logic mode_q,
  output logic done
);
  phase_t ph_q, ph_d;
  logic   mode_d;

  assign idle   = (ph_q == PH_IDLE);
  assign accept = start && idle;
  assign sub_en = (ph_q == PH_KEY);
  assign done   = (ph_q == PH_FIN);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start) ph_d = PH_KEY;
      PH_KEY:  ph_d = PH_SUB;
      PH_SUB:  ph_d = PH_FIN;
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    if (accept) begin
      mode_d = secure_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      mode_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
    end
  end

  // R10: the sampled mode holds for the whole operation
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mode_q));
  // R8: completion lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: an operation is never restarted from a busy phase
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (ph_q != PH_KEY));
endmodule

// File: rtl/cplut_engine.sv
module cplut_engine
  import cplut_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned FN_W   = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      secure_mode,
  input  logic [LANES*LANE_W-1:0]   lane_in,
  input  logic                      load_en,
  input  logic                      load_sel,
  input  logic [FN_W:0]             load_addr,
  input  logic [FN_W:0]             load_data,
  output logic [LANES*LANE_W-1:0]   result,
  output logic                      done
);
  localparam int unsigned IDX_W = FN_W + 1;

  logic accept, sub_en, idle, mode_q;
  logic we_key, we_sub;
  logic [LANES-1:0][IDX_W-1:0] in_idx;
  logic [LANES-1:0][IDX_W-1:0] key_addr, key_data, key_q;
  logic [LANES-1:0][IDX_W-1:0] sub_addr, sub_data, sub_q;

  cplut_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .secure_in (secure_mode),
    .accept    (accept),
    .sub_en    (sub_en),
    .idle      (idle),
    .mode_q    (mode_q),
    .done      (done)
  );

  assign we_key = load_en && idle && (load_sel == SEL_KEY);
  assign we_sub = load_en && idle && (load_sel == SEL_SUB);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_idx[g] = lane_in[g*LANE_W +: IDX_W];
    assign result[g*LANE_W +: LANE_W] = {{(LANE_W-IDX_W){1'b0}}, sub_q[g]};
  end

  cplut_table #(.LANES(LANES), .IDX_W(IDX_W)) u_key_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_key),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_addr (key_addr),
    .rd_data (key_data)
  );

  cplut_table #(.LANES(LANES), .IDX_W(IDX_W)) u_sub_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_sub),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_addr (sub_addr),
    .rd_data (sub_data)
  );

  // key stage samples the live mode on the accepting edge
  cplut_stage #(.LANES(LANES), .IDX_W(IDX_W)) u_key_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (accept),
    .secure   (secure_mode),
    .src      (in_idx),
    .tbl_addr (key_addr),
    .tbl_data (key_data),
    .q        (key_q)
  );

  cplut_stage #(.LANES(LANES), .IDX_W(IDX_W)) u_sub_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (sub_en),
    .secure   (mode_q),
    .src      (key_q),
    .tbl_addr (sub_addr),
    .tbl_data (sub_data),
    .q        (sub_q)
  );

  // R8: done follows an accepted start by exactly three edges
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept, 3));
  // R7: no table write is let through while busy
  assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_key || we_sub) |-> (idle && !$past(accept)));
endmodule

// File: tb/cplut_engine_tb.sv
`timescale 1ns/1ps
module cplut_engine_tb;
  localparam int LANES = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        secure_mode = 1'b0;
  logic [63:0] lane_in = '0;
  logic        load_en = 1'b0;
  logic        load_sel = 1'b0;
  logic [4:0]  load_addr = '0;
  logic [4:0]  load_data = '0;
  logic [63:0] result;
  logic        done;

  always #4 clk = ~clk;

  cplut_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .secure_mode(secure_mode),
    .lane_in(lane_in), .load_en(load_en), .load_sel(load_sel),
    .load_addr(load_addr), .load_data(load_data), .result(result), .done(done)
  );

  localparam logic [3:0] SUBST [16] = '{4'd12, 4'd5, 4'd6, 4'd11, 4'd9, 4'd0, 4'd10, 4'd13,
                                        4'd3, 4'd14, 4'd15, 4'd8, 4'd4, 4'd7, 4'd1, 4'd2};

  typedef struct {
    logic [63:0] exp;
    int          edge_due;
    logic        paired;
    string       req;
  } item_t;

  item_t       sb_q[$];
  logic [4:0]  img_key [32];
  logic [4:0]  img_sub [32];
  int          edges = 0;
  int          checks = 0;
  int          errors = 0;
  int          done_seen = 0;
  logic        prev_done = 1'b0;

  always @(posedge clk) edges <= edges + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] fn_val(input bit sub, input logic [3:0] x, input logic [3:0] key);
    return sub ? {1'b0, SUBST[x]} : {1'b0, x ^ key};
  endfunction

  task automatic load_table(input bit sub, input logic [3:0] key);
    for (int x = 0; x < 16; x++) begin
      logic [4:0] lo;
      logic [4:0] hi;
      lo = fn_val(sub, 4'(x), key);
      hi = {1'b1, ~lo[3:0]};
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        load_en   = 1'b1;
        load_sel  = sub;
        load_addr = (h == 0) ? 5'(x) : {1'b1, ~4'(x)};
        load_data = (h == 0) ? lo : hi;
        if (sub) img_sub[load_addr] = load_data;
        else     img_key[load_addr] = load_data;
      end
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  function automatic logic [63:0] model(input logic [63:0] vin, input bit sec);
    logic [63:0] r = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [4:0] i;
      logic [4:0] a;
      i = vin[l*8 +: 5];
      if (!sec) i[4] = 1'b0;
      a = img_key[i];
      if (!sec) a[4] = 1'b0;
      r[l*8 +: 8] = {3'b000, img_sub[a]};
    end
    return r;
  endfunction

  // drive start for one cycle (called just after a negedge)
  task automatic fire(input logic [63:0] vin, input bit sec, input bit paired, input string req);
    item_t it;
    lane_in     = vin;
    secure_mode = sec;
    start       = 1'b1;
    it.exp      = model(vin, sec);
    it.edge_due = edges + 3;
    it.paired   = paired;
    it.req      = req;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] pairs(input logic [3:0] x0, input logic [3:0] x1,
                                        input logic [3:0] x2, input logic [3:0] x3);
    logic [3:0] xs [4];
    logic [63:0] v = '0;
    xs = '{x0, x1, x2, x3};
    for (int p = 0; p < 4; p++) begin
      v[(2*p)*8 +: 8]   = {3'b000, 1'b0, xs[p]};
      v[(2*p+1)*8 +: 8] = {3'b000, 1'b1, ~xs[p]};
    end
    return v;
  endfunction

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(1'b0, "R8 pulse width", {63'd0, done}, 64'd0);
      if (done && !prev_done) begin
        done_seen++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", result, 64'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(result === it.exp, it.req, result, it.exp);
          check(edges == it.edge_due, "R8 latency", 64'(edges), 64'(it.edge_due));
          if (it.paired) begin
            for (int p = 0; p < 4; p++) begin
              int w;
              w = $countones(result[(2*p)*8 +: 5]) + $countones(result[(2*p+1)*8 +: 5]);
              check(w == 5, "R3 pair weight", 64'(w), 64'd5);
            end
          end
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    int          d0;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1 done", {63'd0, done}, 64'd0);
    check(result === 64'd0, "R1 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: identity key, known substitution entries
    load_table(1'b0, 4'h0);
    load_table(1'b1, 4'h0);
    fire(pairs(4'h0, 4'hF, 4'h0, 4'hF), 1'b1, 1'b1, "R4 subst ends");
    idle_cycles(4);
    check(result[7:0] == 8'd12 && result[15:8] == 8'd19, "R4 addr0/31", result[15:0], 64'h130C);
    check(result[23:16] == 8'd2 && result[31:24] == 8'd29, "R4 x=15", result[31:16], 64'h1D02);

    // R2/R5: key 0xA, several pair patterns
    load_table(1'b0, 4'hA);
    fire(pairs(4'h0, 4'h5, 4'hA, 4'hF), 1'b1, 1'b1, "R2 secure pairs key A");
    idle_cycles(4);
    fire(pairs(4'h3, 4'h9, 4'hC, 4'h6), 1'b1, 1'b1, "R5 key A second pattern");
    idle_cycles(4);
    load_table(1'b0, 4'h3);
    fire(pairs(4'h3, 4'h9, 4'hC, 4'h6), 1'b1, 1'b1, "R5 key 3 reload");
    idle_cycles(4);

    // R6/R11: fast mode, tag and upper bits set on some lanes
    fire(64'hF3_1A_E7_05_B2_19_FF_10, 1'b0, 1'b0, "R6 R11 fast lanes");
    idle_cycles(4);
    check(result[63:61] == 3'b000 && result[7:5] == 3'b000, "R11 upper bits", result, 64'd0);

    // R7: write during busy discarded (key index 0 stays 0|3)
    fire(pairs(4'h1, 4'h2, 4'h4, 4'h8), 1'b1, 1'b1, "R7 op during load");
    load_en = 1'b1; load_sel = 1'b0; load_addr = 5'd0; load_data = 5'd9;
    @(negedge clk);
    load_en = 1'b0;
    idle_cycles(3);
    fire(64'h0, 1'b0, 1'b0, "R7 table unchanged");
    idle_cycles(4);

    // R9: extra start while busy ignored
    d0 = done_seen;
    fire(pairs(4'h7, 4'hB, 4'hD, 4'hE), 1'b1, 1'b1, "R9 first op");
    lane_in = 64'h0F0F0F0F_0F0F0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle_cycles(5);
    check(done_seen == d0 + 1, "R9 done count", 64'(done_seen), 64'(d0 + 1));

    // R10: mode flips during operation
    fire(pairs(4'h2, 4'h6, 4'hA, 4'hE), 1'b1, 1'b1, "R10 mode held");
    secure_mode = 1'b0;
    idle_cycles(4);

    // R11: result held after completion
    held = result;
    idle_cycles(3);
    check(result === held, "R11 hold", result, held);
    check(sb_q.size() == 0, "R8 all done", 64'(sb_q.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule